// File: doc/BRIEF.md
# X–Y Addressable Scan Storage Array

This block is a grid of single-bit storage cells that serve two purposes. In normal operation every cell captures its own functional data bit when the functional clock falls. In test operation, any one cell can be reached by its row and column address. That cell can be written from a shared scan data line, and its contents can be observed on a single chip-level scan-out pin, without shifting a serial chain.

Each cell is selected only when both its row line and its column line are active. A binary row address and a binary column address are decoded into one-hot row and column select vectors. A scan-enable input gates both decoders, so with scan-enable low no cell is selected. Every cell drives its own scan-out line. That line is high when the cell is not selected, and it carries the inverse of the stored bit when the cell is selected. The lines are combined by an AND into the chip scan-out, so the pin shows only the selected cell.

The functional clock and the scan clock are level inputs that the block samples on its system clock `clk`. A falling functional-clock level or a rising scan-clock level, seen between two `clk` edges, acts at the second of those edges. All cells are ordinary edge-triggered flops.

Top module: `rasa_array`

## Requirements
- R1: A synchronous active-high `rst` clears every cell to 0 at the next `clk` edge. After reset, `scanOut` is 1 while `scanEn` is low.
- R2: Cell (r,c) is stored at bit r*COLS+c of `funcDout`. It is selected only when `scanEn` is 1, `rowAddr` equals r and `colAddr` equals c. At most one cell is selected at a time.
- R3: When `scanClk` was 0 at the previous `clk` edge and is 1 at the current edge, with `scanEn` high, the selected cell loads `scanDin` at that edge.
- R4: A scan-clock rise leaves every unselected cell unchanged. A scan-clock rise while `scanEn` is low changes no cell at all.
- R5: When `funcClk` was 1 at the previous `clk` edge and is 0 at the current edge, every cell loads its own bit of `funcDin` at that edge.
- R6: While `scanEn` is high, `scanOut` equals the inverse of the selected cell's stored bit.
- R7: An unselected cell never pulls `scanOut` low. While `scanEn` is low, `scanOut` is 1 for every address and every stored pattern.
- R8: If a functional fall and a scan rise act at the same `clk` edge, the selected cell takes `scanDin` and all other cells take `funcDin`.
- R9: With no functional fall and no enabled scan rise, all cells keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both test clocks |
| rst | input | 1 | Synchronous active-high reset |
| funcClk | input | 1 | Functional capture clock level; a fall loads all cells |
| scanClk | input | 1 | Scan clock level; a rise writes the selected cell |
| scanEn | input | 1 | Enables the address decoders |
| rowAddr | input | ROW_W | Binary row address |
| colAddr | input | COL_W | Binary column address |
| scanDin | input | 1 | Shared scan write data |
| funcDin | input | ROWS*COLS | Functional data, one bit per cell, bit r*COLS+c |
| funcDout | output | ROWS*COLS | Stored cell values, bit r*COLS+c |
| scanOut | output | 1 | AND of all per-cell scan-out lines |

## Verification
The assertions check the following on every cycle:
- the scan-out pin stays high whenever scan is disabled;
- the pin carries the inverse of the addressed cell whenever scan is enabled;
- a scan-only event changes at most one cell, and no cell changes without an event;
- an enabled scan rise leaves the written value in the addressed cell, even when a functional fall lands at the same edge;
- the array is cleared after reset.

Only the bench's scenarios can show that a full pattern survives writes to all other addresses, that each cell reads back correctly through the inverted pin, and that the exact functional word reaches every cell.

// File: rtl/rasa_pkg.sv
package rasa_pkg;
  // Strobes sent from control to datapath, one per capture kind
  typedef struct packed {
    logic funcLoad;
    logic scanLoad;
  } rasaStrobe_t;
endpackage

// File: rtl/rasa_ctrl.sv
module rasa_ctrl
  import rasa_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int ROW_W = 2,
  parameter int COL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             funcClk,
  input  logic             scanClk,
  input  logic             scanEn,
  input  logic [ROW_W-1:0] rowAddr,
  input  logic [COL_W-1:0] colAddr,
  output rasaStrobe_t      strobe,
  output logic [ROWS-1:0]  rowSel,
  output logic [COLS-1:0]  colSel
);
  logic funcClkQ;
  logic scanClkQ;

  // The reset levels are chosen so that leaving reset never produces a false edge
  always_ff @(posedge clk) begin
    if (rst) begin
      funcClkQ <= 1'b0;
      scanClkQ <= 1'b1;
    end else begin
      funcClkQ <= funcClk;
      scanClkQ <= scanClk;
    end
  end

  always_comb begin
    strobe.funcLoad = !rst && funcClkQ && !funcClk;
    strobe.scanLoad = !rst && !scanClkQ && scanClk;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_rowDec
    assign rowSel[r] = scanEn && (rowAddr == ROW_W'(r));
  end

  for (genvar c = 0; c < COLS; c++) begin : g_colDec
    assign colSel[c] = scanEn && (colAddr == COL_W'(c));
  end
endmodule

// File: rtl/rasa_cell.sv
module rasa_cell (
  input  logic clk,
  input  logic rst,
  input  logic funcLoad,
  input  logic scanLoad,
  input  logic xSel,
  input  logic ySel,
  input  logic funcD,
  input  logic scanD,
  output logic q,
  output logic cellSo
);
  logic sel;

  assign sel = xSel && ySel;

  // A scan write to the selected cell takes priority over functional capture
  always_ff @(posedge clk) begin
    if (rst)                  q <= 1'b0;
    else if (scanLoad && sel) q <= scanD;
    else if (funcLoad)        q <= funcD;
  end

  assign cellSo = sel ? ~q : 1'b1;
endmodule

// File: rtl/rasa_cells.sv
module rasa_cells
  import rasa_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int CELLS = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst,
  input  rasaStrobe_t      strobe,
  input  logic [ROWS-1:0]  rowSel,
  input  logic [COLS-1:0]  colSel,
  input  logic             scanDin,
  input  logic [CELLS-1:0] funcDin,
  output logic [CELLS-1:0] cellQ,
  output logic             scanOut
);
  logic [CELLS-1:0] cellSo;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      rasa_cell cell_i (
        .clk     (clk),
        .rst     (rst),
        .funcLoad(strobe.funcLoad),
        .scanLoad(strobe.scanLoad),
        .xSel    (rowSel[r]),
        .ySel    (colSel[c]),
        .funcD   (funcDin[r*COLS+c]),
        .scanD   (scanDin),
        .q       (cellQ[r*COLS+c]),
        .cellSo  (cellSo[r*COLS+c])
      );
    end
  end

  assign scanOut = &cellSo;
endmodule

// File: rtl/rasa_array.sv
module rasa_array
  import rasa_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CELLS = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             funcClk,
  input  logic             scanClk,
  input  logic             scanEn,
  input  logic [ROW_W-1:0] rowAddr,
  input  logic [COL_W-1:0] colAddr,
  input  logic             scanDin,
  input  logic [CELLS-1:0] funcDin,
  output logic [CELLS-1:0] funcDout,
  output logic             scanOut
);
  rasaStrobe_t      strobe;
  logic [ROWS-1:0]  rowSel;
  logic [COLS-1:0]  colSel;

  rasa_ctrl #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .funcClk(funcClk),
    .scanClk(scanClk),
    .scanEn (scanEn),
    .rowAddr(rowAddr),
    .colAddr(colAddr),
    .strobe (strobe),
    .rowSel (rowSel),
    .colSel (colSel)
  );

  rasa_cells #(.ROWS(ROWS), .COLS(COLS)) cells_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .rowSel (rowSel),
    .colSel (colSel),
    .scanDin(scanDin),
    .funcDin(funcDin),
    .cellQ  (funcDout),
    .scanOut(scanOut)
  );
endmodule

// File: rtl/rasa_array_chk.sv
module rasa_array_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CELLS = ROWS * COLS
) (
  input logic             clk,
  input logic             rst,
  input logic             funcClk,
  input logic             scanClk,
  input logic             scanEn,
  input logic [ROW_W-1:0] rowAddr,
  input logic [COL_W-1:0] colAddr,
  input logic             scanDin,
  input logic [CELLS-1:0] funcDout,
  input logic             scanOut
);
  logic funcSeen;
  logic scanSeen;
  logic wrPend;
  int   wrIdx;
  logic wrVal;
  int   curIdx;
  logic fallNow;
  logic riseNow;

  assign curIdx  = int'(rowAddr) * COLS + int'(colAddr);
  assign fallNow = funcSeen && !funcClk;
  assign riseNow = !scanSeen && scanClk;

  always_ff @(posedge clk) begin
    if (rst) begin
      funcSeen <= 1'b0;
      scanSeen <= 1'b1;
      wrPend   <= 1'b0;
      wrIdx    <= 0;
      wrVal    <= 1'b0;
    end else begin
      funcSeen <= funcClk;
      scanSeen <= scanClk;
      wrPend   <= riseNow && scanEn && (curIdx < CELLS);
      wrIdx    <= curIdx;
      wrVal    <= scanDin;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (funcDout == '0));

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !scanEn |-> scanOut);

  // R6
  inverted_view_chk: assert property (@(posedge clk) disable iff (rst)
    (scanEn && curIdx < CELLS) |-> (scanOut == !funcDout[curIdx]));

  // R3 and R8
  scan_write_chk: assert property (@(posedge clk) disable iff (rst)
    wrPend |-> (funcDout[wrIdx] == wrVal));

  // R4
  single_cell_chk: assert property (@(posedge clk) disable iff (rst)
    !fallNow |=> ($countones(funcDout ^ $past(funcDout)) <= 1));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fallNow && !(riseNow && scanEn)) |=> $stable(funcDout));
endmodule

bind rasa_array rasa_array_chk #(.ROWS(ROWS), .COLS(COLS)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .funcClk (funcClk),
  .scanClk (scanClk),
  .scanEn  (scanEn),
  .rowAddr (rowAddr),
  .colAddr (colAddr),
  .scanDin (scanDin),
  .funcDout(funcDout),
  .scanOut (scanOut)
);

// File: tb/rasa_array_tb.sv
module rasa_array_tb_top;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int CELLS = ROWS * COLS;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             funcClk = 1'b0;
  logic             scanClk = 1'b0;
  logic             scanEn = 1'b0;
  logic [1:0]       rowAddr = '0;
  logic [1:0]       colAddr = '0;
  logic             scanDin = 1'b0;
  logic [CELLS-1:0] funcDin = '0;
  logic [CELLS-1:0] funcDout;
  logic             scanOut;

  logic [CELLS-1:0] expQ = '0;
  int               nRun = 0;
  int               nFail = 0;
  bit               finished = 0;

  always #5 clk = ~clk;

  rasa_array #(.ROWS(ROWS), .COLS(COLS)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .funcClk (funcClk),
    .scanClk (scanClk),
    .scanEn  (scanEn),
    .rowAddr (rowAddr),
    .colAddr (colAddr),
    .scanDin (scanDin),
    .funcDin (funcDin),
    .funcDout(funcDout),
    .scanOut (scanOut)
  );

  task automatic checkVec(string req, logic [CELLS-1:0] act, logic [CELLS-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One scan write: the rise is applied, acts at the next edge, then the clock is released
  task automatic scanWrite(int r, int c, logic v, logic en);
    @(negedge clk);
    rowAddr = 2'(r); colAddr = 2'(c); scanDin = v; scanEn = en; scanClk = 1'b1;
    @(negedge clk);
    scanClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic funcPulse(logic [CELLS-1:0] d);
    @(negedge clk);
    funcDin = d; funcClk = 1'b1;
    @(negedge clk);
    funcClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic readAll(string req);
    for (int i = 0; i < CELLS; i++) begin
      @(negedge clk);
      scanEn = 1'b1; rowAddr = 2'(i / COLS); colAddr = 2'(i % COLS);
      #1;
      checkBit(req, scanOut, ~expQ[i]);
    end
    scanEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: cleared, pin high with scan disabled
    checkVec("R1 reset cells", funcDout, '0);
    checkBit("R1 reset scanOut", scanOut, 1'b1);

    // R3 and R2: write a distinct pattern, checking the whole word after each write
    for (int i = 0; i < CELLS; i++) begin
      logic v;
      v = ((i % 3) == 0) ^ (i >= 8);
      scanWrite(i / COLS, i % COLS, v, 1'b1);
      expQ[i] = v;
      checkVec("R3 scan write", funcDout, expQ);
    end

    // R6: every cell seen inverted on the pin
    readAll("R6 readback");

    // R7: scan disabled, every address keeps the pin high
    for (int i = 0; i < CELLS; i++) begin
      @(negedge clk);
      scanEn = 1'b0; rowAddr = 2'(i / COLS); colAddr = 2'(i % COLS);
      #1;
      checkBit("R7 unselected high", scanOut, 1'b1);
    end

    // R4: a rise with scan disabled writes nothing
    scanWrite(1, 2, ~expQ[6], 1'b0);
    checkVec("R4 disabled rise", funcDout, expQ);
    checkBit("R7 disabled pin", scanOut, 1'b1);

    // R9: idle cycles hold
    repeat (4) @(negedge clk);
    checkVec("R9 hold", funcDout, expQ);

    // R5: functional capture, then scanned out
    funcPulse(16'hA5C3);
    expQ = 16'hA5C3;
    checkVec("R5 functional load", funcDout, expQ);
    readAll("R5 functional scan-out");
    funcPulse(16'h3C96);
    expQ = 16'h3C96;
    checkVec("R5 functional load 2", funcDout, expQ);

    // R8: functional fall and scan rise at the same edge, cell (2,1) = bit 9
    @(negedge clk);
    funcDin = '0; funcClk = 1'b1;
    @(negedge clk);
    funcClk = 1'b0; scanClk = 1'b1; scanEn = 1'b1;
    rowAddr = 2'd2; colAddr = 2'd1; scanDin = 1'b1;
    @(negedge clk);
    scanClk = 1'b0;
    expQ = 16'h0200;
    checkVec("R8 scan priority", funcDout, expQ);
    #1;
    checkBit("R8 selected pin", scanOut, 1'b0);
    scanEn = 1'b0;

    // R1: reset during operation clears the array
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expQ = '0;
    checkVec("R1 mid reset", funcDout, expQ);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule